// File: doc/BRIEF.md
# Iterative Reciprocal Floating-Point Divider

This block divides two 12-bit floating-point numbers. The divisor's exponent selects a starting guess for its reciprocal. The guess is then refined a fixed number of times with the step x ← x·(2 − d·x), which converges quadratically on 1/d. One final multiply by the numerator gives the quotient.

The hardware is deliberately small. One multiplier and one adder serve every step of the refinement and the final product, selected by multiplexers under a short state machine. A control module steps through the operations and a datapath module holds the operands and partial results. Software or a neighbouring block pulses `start` with both operands present, waits for `done`, and reads `quotient`. The result stays put until the next `start`.

Top module: `float_recip_div`

## Requirements
- R1: Number format: bit 11 is the sign, bits 10:7 are a 4-bit exponent with a bias of 7, and bits 6:0 are the fraction below a hidden leading 1, so a word means (−1)^s · 1.f · 2^(e−7). An exponent field of 0 means zero, whatever the fraction bits are.
- R2: While reset is active, and after it is released, `done` is 0, `quotient` is 0x000 and `divByZero` is 0.
- R3: A `start` sampled high at a rising edge captures `numIn` and `denIn`. `done` is 0 after that edge.
- R4: For a non-zero divisor, `done` rises at the 3·ITERS+1-th rising edge after the capturing edge. This is 61 edges at the default of 20 iterations.
- R5: For in-range results, `quotient` lies within one unit in the last place of the exact quotient, taking that unit at the binade of the exact value. The sign bit of `quotient` is the XOR of the operand signs.
- R6: Once `done` is high, `done`, `quotient` and `divByZero` hold their values until the next `start`.
- R7: A zero divisor skips the refinement. `done` rises at the first rising edge after capture, with `divByZero` = 1 and `quotient` = {sign of numerator, eleven 1 bits}.
- R8: A zero numerator with a non-zero divisor gives `quotient` = 0x000 and `divByZero` = 0.
- R9: When the result exponent would exceed 15, `quotient` saturates to {sign XOR, eleven 1 bits}.
- R10: When the result falls below 2^−6, `quotient` is 0x000.
- R11: The starting guess for a divisor exponent e approximates 1/(1.5·2^(e−7)). With this guess the refinement converges for every divisor fraction, from 1.0 up to 1.9921875.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands and begin a division |
| numIn | input | 12 | Numerator (dividend) |
| denIn | input | 12 | Denominator (divisor) |
| quotient | output | 12 | Result, valid while `done` is high |
| done | output | 1 | Result ready; held until the next `start` |
| divByZero | output | 1 | Set with the result when the divisor was zero |

## Verification
The bench targets divisors at both ends of the fraction range. A poor seed or a broken refinement step would leave the reciprocal short there and push the quotient more than one unit off. Results that land exactly on a power of two are also checked, because a truncating datapath can fall just under them and change binade. Exponent overflow and underflow are checked, since mishandling them wraps the 4-bit exponent into a small or huge wrong value. A zero divisor is checked for its short latency and saturated result, and a zero numerator for returning true zero rather than the hidden-1 product. Each run's latency is checked as well, which catches a miscounted iteration loop.

// File: rtl/float_recip_div_pkg.sv
package float_recip_div_pkg;
  localparam int EXP_W  = 4;
  localparam int MAN_W  = 7;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic load;     // capture operands, seed the estimate
    logic mulDx;    // product d*x
    logic subTwo;   // 2 - product
    logic mulXt;    // x * (2 - d*x)
    logic finish;   // n * x, pack and load quotient
  } ctrlStrobes_t;
endpackage

// File: rtl/float_recip_div_ctrl.sv
module float_recip_div_ctrl
  import float_recip_div_pkg::*;
#(
  parameter int ITERS = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         denZero,
  output ctrlStrobes_t strobes,
  output logic         done
);
  localparam int CNT_W = $clog2(ITERS + 1);

  typedef enum logic [2:0] {IDLE, MUL_DX, SUB_TWO, MUL_XT, FINISH} state_t;
  state_t state;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    strobes = '0;
    if (start) strobes.load = 1'b1;
    else begin
      strobes.mulDx  = (state == MUL_DX);
      strobes.subTwo = (state == SUB_TWO);
      strobes.mulXt  = (state == MUL_XT);
      strobes.finish = (state == FINISH);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else if (start) begin
      state   <= denZero ? FINISH : MUL_DX;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        MUL_DX:  state <= SUB_TWO;
        SUB_TWO: state <= MUL_XT;
        MUL_XT: begin
          iterCnt <= iterCnt + 1'b1;
          state   <= (iterCnt == CNT_W'(ITERS - 1)) ? FINISH : MUL_DX;
        end
        FINISH: begin
          done  <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/float_recip_div_dp.sv
module float_recip_div_dp
  import float_recip_div_pkg::*;
#(
  parameter int FRAC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] numIn,
  input  logic [WORD_W-1:0] denIn,
  output logic              denZero,
  output logic [WORD_W-1:0] quotient,
  output logic              divByZero
);
  localparam int W    = FRAC + 2;
  localparam int PW   = 2 * W;
  localparam int XW   = EXP_W + 2;
  localparam logic [W-1:0] TWO      = W'(2) << FRAC;
  localparam logic [W-1:0] SEED_SIG = W'((2 ** (FRAC + 1) + 1) / 3);
  localparam logic signed [XW-1:0] MAX_EXP = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] MIN_EXP = XW'(1);

  // Seed exponent per divisor exponent code: reciprocal binade of 1.5*2^(e-BIAS)
  logic signed [XW-1:0] seedExpTab [1 << EXP_W];
  for (genvar e = 0; e < (1 << EXP_W); e++) begin : g_seed
    assign seedExpTab[e] = XW'(BIAS - e);
  end

  logic [EXP_W-1:0] nExp, dExp;
  assign nExp    = numIn[WORD_W-2 -: EXP_W];
  assign dExp    = denIn[WORD_W-2 -: EXP_W];
  assign denZero = (dExp == '0);

  logic [W-1:0] dSig, nSig, xReg, pReg, tReg;
  logic signed [XW-1:0] expBase;
  logic signR, nZeroR, dZeroR;

  // Shared multiplier and adder
  logic [W-1:0]  mulA, mulRes, addRes;
  logic [PW-1:0] mulFull;
  always_comb begin
    if (strobes.mulDx)      mulA = dSig;
    else if (strobes.mulXt) mulA = tReg;
    else                    mulA = nSig;
    mulFull = PW'(mulA) * PW'(xReg);
    mulRes  = W'(mulFull >> FRAC);
    addRes  = TWO + ~pReg + W'(1);
  end

  // Normalize and pack
  logic                 normHi;
  logic [W-1:0]         normSig;
  logic [MAN_W-1:0]     fracOut;
  logic signed [XW-1:0] expOut;
  logic [WORD_W-1:0]    packed_q;
  always_comb begin
    normHi  = mulRes[FRAC];
    normSig = normHi ? mulRes : (mulRes << 1);
    fracOut = MAN_W'(normSig >> (FRAC - MAN_W));
    expOut  = normHi ? expBase : expBase - XW'(1);
    if (dZeroR)                packed_q = {signR, {(WORD_W-1){1'b1}}};
    else if (nZeroR)           packed_q = '0;
    else if (expOut > MAX_EXP) packed_q = {signR, {(WORD_W-1){1'b1}}};
    else if (expOut < MIN_EXP) packed_q = '0;
    else                       packed_q = {signR, expOut[EXP_W-1:0], fracOut};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dSig <= '0; nSig <= '0; xReg <= '0; pReg <= '0; tReg <= '0;
      expBase <= '0; signR <= 1'b0; nZeroR <= 1'b0; dZeroR <= 1'b0;
      quotient <= '0; divByZero <= 1'b0;
    end else if (strobes.load) begin
      dSig    <= W'({1'b1, denIn[MAN_W-1:0]}) << (FRAC - MAN_W);
      nSig    <= W'({1'b1, numIn[MAN_W-1:0]}) << (FRAC - MAN_W);
      xReg    <= SEED_SIG;
      expBase <= $signed({2'b00, nExp}) + seedExpTab[dExp];
      signR   <= numIn[WORD_W-1] ^ (denZero ? 1'b0 : denIn[WORD_W-1]);
      nZeroR  <= (nExp == '0);
      dZeroR  <= denZero;
    end else begin
      if (strobes.mulDx)  pReg <= mulRes;
      if (strobes.subTwo) tReg <= addRes;
      if (strobes.mulXt)  xReg <= mulRes;
      if (strobes.finish) begin
        quotient  <= packed_q;
        divByZero <= dZeroR;
      end
    end
  end
endmodule

// File: rtl/float_recip_div.sv
module float_recip_div
  import float_recip_div_pkg::*;
#(
  parameter int ITERS = 20,
  parameter int FRAC  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [11:0] numIn,
  input  logic [11:0] denIn,
  output logic [11:0] quotient,
  output logic        done,
  output logic        divByZero
);
  ctrlStrobes_t strobes;
  logic denZero;

  float_recip_div_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .denZero(denZero),
    .strobes(strobes), .done(done)
  );

  float_recip_div_dp #(.FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .numIn(numIn), .denIn(denIn),
    .denZero(denZero), .quotient(quotient), .divByZero(divByZero)
  );
endmodule

// File: rtl/float_recip_div_chk.sv
module float_recip_div_chk #(
  parameter int ITERS = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [11:0] quotient,
  input logic        done,
  input logic        divByZero
);
  logic [15:0] sinceStart;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceStart <= '0;
    else if (start)            sinceStart <= '0;
    else if (sinceStart != '1) sinceStart <= sinceStart + 1'b1;
  end

  // R3
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

  // R4 and R7
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (sinceStart == (divByZero ? 16'd1 : 16'(3 * ITERS + 1))));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(quotient) && $stable(divByZero)));

  // R7
  zero_div_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && divByZero) |-> (&quotient[10:0]));
endmodule

bind float_recip_div float_recip_div_chk #(.ITERS(ITERS)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .quotient(quotient),
  .done(done), .divByZero(divByZero)
);

// File: tb/float_recip_div_bench.sv
module float_recip_div_bench;
  localparam int ITERS = 20;
  localparam int NORM_LAT = 3 * ITERS + 1;
  localparam int NVEC = 9;
  // {numerator, denominator}
  localparam logic [23:0] VECS [NVEC] = '{
    {12'h440, 12'h3C0},   // 3 / 1.5
    {12'h380, 12'h380},   // 1 / 1
    {12'h380, 12'h3FF},   // 1 / 1.9921875
    {12'hCA0, 12'h440},   // -5 / 3
    {12'h4E0, 12'hB40},   // 7 / -0.75
    {12'h520, 12'h1CD},   // 10 / ~0.1
    {12'hBFF, 12'hB80},   // -1.9921875 / -1
    {12'h080, 12'h300},   // 2^-6 / 0.5
    {12'h748, 12'h38D}    // 200 / ~1.1
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [11:0] numIn = '0, denIn = '0;
  logic [11:0] quotient;
  logic done, divByZero;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  float_recip_div #(.ITERS(ITERS)) u_float_recip_div (
    .clk(clk), .rstN(rstN), .start(start), .numIn(numIn), .denIn(denIn),
    .quotient(quotient), .done(done), .divByZero(divByZero)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  // R1 decode
  function automatic real decode(input logic [11:0] w);
    real m;
    if (w[10:7] == 4'd0) return 0.0;
    m = (1.0 + real'(w[6:0]) / 128.0) * pow2(int'(w[10:7]) - 7);
    return w[11] ? -m : m;
  endfunction

  task automatic runDiv(input logic [11:0] a, input logic [11:0] b,
                        output logic [11:0] q, output int lat, output logic z);
    @(negedge clk);
    numIn = a; denIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R3", $sformatf("done after start act=%0b exp=0", done));
    lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (done || lat > 400) break;
    end
    q = quotient; z = divByZero;
  endtask

  task automatic expectCode(input logic [11:0] a, input logic [11:0] b,
                            input logic [11:0] expQ, input logic expZ,
                            input int expLat, input string req);
    logic [11:0] q; int lat; logic z;
    runDiv(a, b, q, lat, z);
    chk(q == expQ, req, $sformatf("%h/%h quotient act=%h exp=%h", a, b, q, expQ));
    chk(z == expZ, req, $sformatf("%h/%h flag act=%0b exp=%0b", a, b, z, expZ));
    chk(lat == expLat, req, $sformatf("%h/%h latency act=%0d exp=%0d", a, b, lat, expLat));
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] q, hq; int lat; logic z;
    real ex, mag, ulp, got; int k;

    // R2 reset state
    #5;
    chk(done == 0 && quotient == 0 && divByZero == 0, "R2",
        $sformatf("in reset act=%0b/%h/%0b exp=0/000/0", done, quotient, divByZero));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 0 && quotient == 0 && divByZero == 0, "R2",
        $sformatf("after reset act=%0b/%h/%0b exp=0/000/0", done, quotient, divByZero));

    // R5 / R11 / R4: vector walk
    for (int v = 0; v < NVEC; v++) begin
      runDiv(VECS[v][23:12], VECS[v][11:0], q, lat, z);
      ex  = decode(VECS[v][23:12]) / decode(VECS[v][11:0]);
      mag = ex < 0.0 ? -ex : ex;
      k = 0;
      while (mag >= 2.0) begin mag = mag / 2.0; k++; end
      while (mag < 1.0)  begin mag = mag * 2.0; k--; end
      ulp = pow2(k - 7);
      got = decode(q);
      chk((got - ex <= ulp) && (ex - got <= ulp), "R5 R11",
          $sformatf("vec %0d act=%h (%g) exp=%g", v, q, got, ex));
      chk(q[11] == (VECS[v][23] ^ VECS[v][11]), "R5",
          $sformatf("vec %0d sign act=%0b exp=%0b", v, q[11], VECS[v][23] ^ VECS[v][11]));
      chk(lat == NORM_LAT, "R4", $sformatf("vec %0d latency act=%0d exp=%0d", v, lat, NORM_LAT));
      chk(z == 1'b0, "R5", $sformatf("vec %0d flag act=%0b exp=0", v, z));
    end

    // R7 zero divisor, both zero signs
    expectCode(12'hCA0, 12'h000, 12'hFFF, 1'b1, 1, "R7");
    expectCode(12'h3C0, 12'h800, 12'h7FF, 1'b1, 1, "R7");
    // R8 zero numerator; flag clears after a divide-by-zero
    expectCode(12'h000, 12'h440, 12'h000, 1'b0, NORM_LAT, "R8");
    // R9 overflow, both signs
    expectCode(12'h7FF, 12'h080, 12'h7FF, 1'b0, NORM_LAT, "R9");
    expectCode(12'hFFF, 12'h080, 12'hFFF, 1'b0, NORM_LAT, "R9");
    // R10 underflow
    expectCode(12'h080, 12'h7FF, 12'h000, 1'b0, NORM_LAT, "R10");

    // R6 hold after completion
    runDiv(12'h440, 12'h3C0, q, lat, z);
    hq = q;
    repeat (25) @(negedge clk);
    chk(done == 1'b1 && quotient == hq && divByZero == 1'b0, "R6",
        $sformatf("hold act=%0b/%h exp=1/%h", done, quotient, hq));
    numIn = 12'h380; denIn = 12'h000;
    repeat (4) @(negedge clk);
    chk(quotient == hq && divByZero == 1'b0, "R6",
        $sformatf("inputs changed without start act=%h exp=%h", quotient, hq));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule